// File: doc/BRIEF.md
# Programmable Down-Count Timer with Shaped Output

This block is a 14-bit down counter. It advances on rising edges of a slow, asynchronous timer input, which it first synchronizes to the system clock. Software writes a 16-bit length word one byte at a time. The low 14 bits set the count length N and the top two bits pick one of four output shapes. A two-bit command then starts the timer, stops it at once, or stops it once the current count period is done.

Each count period runs N, N-1, ... 1, one timer-input edge per step. The counter reaches 1 once per period, and in that clock cycle the block raises a one-cycle terminal-count strobe for the status logic. Two modes reload by themselves and run until told to stop. The other two make a single pass and go idle. A START that arrives while the timer is running is held back until the present period ends. A hardware reset halts counting but keeps the length word, so the timer stays idle until the next START.

Top module: `prog_mode_timer`

## Requirements
- R1: A write with `len_lo_we_i` stores `wdata_i` into length bits 7:0, and a write with `len_hi_we_i` stores `wdata_i[7:0]` into bits 15:8. Bits 13:0 hold the count length N (legal range 2 to 0x3FFF). Bits 15:14 hold the output mode.
- R2: While running, each rising edge of `tmr_in_i`, after synchronization, moves the counter one step through the sequence N, N-1, ..., 1.
- R3: In modes 0 and 1 the output is high while the counter is greater than floor(N/2) and low otherwise, so an odd N spends the larger half high (N=9 gives 5 steps high, then 4 low).
- R4: Modes 1 and 3 reload N after the step at 1, so each period lasts N input edges. Modes 0 and 2 stop after one period and the output returns high.
- R5: In modes 2 and 3 the output is low only during the step in which the counter holds 1.
- R6: `tc_pulse_o` is high for exactly one clock, in the cycle in which the counter moves from 2 to 1.
- R7: Command 2'b00 has no effect on a running count.
- R8: Command 2'b01 stops a running timer at once. Afterwards the output stays high and no further terminal count occurs.
- R9: Command 2'b10 lets the running period finish, including its terminal count, and then stops the timer. When the timer is idle, this command has no effect.
- R10: Command 2'b11 on an idle timer loads N and the mode from the length word and starts counting on the next clock. On a running timer, the current period completes under the old settings, and the length word is then applied at the wrap.
- R11: While stopped, the output is high and `tc_pulse_o` stays low.
- R12: Reset stops the timer and drives the output high. It leaves the length word intact, and no counting happens until a START command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_in_i | input | 1 | Asynchronous timer input; rising edges are counted |
| len_lo_we_i | input | 1 | Write strobe for the low byte of the length word |
| len_hi_we_i | input | 1 | Write strobe for the high byte of the length word |
| wdata_i | input | 8 | Byte written into the length word |
| cmd_we_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command: 00 none, 01 stop, 10 stop after terminal count, 11 start |
| tmr_out_o | output | 1 | Shaped timer output |
| tc_pulse_o | output | 1 | One-cycle terminal-count strobe |

## Verification
The bench uses the default parameters: a 14-bit counter and a two-stage synchronizer. It programs short lengths from 2 to 9, so every mode wraps several times within a few dozen input edges. Those runs cover both odd and even halves, the minimum length of 2, and commands landing in the middle of a period. The full 14-bit width is exercised only through the byte-wise loading path.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_STOP    = 2'b01,
    CMD_STOP_TC = 2'b10,
    CMD_START   = 2'b11
  } tmr_cmd_e;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], async_i};
      last_q <= sr_q[STAGES-1];
    end
  end

  assign rise_o = sr_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_len_reg.sv
module tmr_len_reg #(
  parameter int CNT_W = 14,
  localparam int LEN_W = CNT_W + 2,
  localparam int HI_W  = LEN_W - 8
) (
  input  logic             clk_i,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [7:0]       wdata_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] len_q;

  // no reset: the length word survives a hardware reset
  always_ff @(posedge clk_i) begin
    if (lo_we_i) len_q[7:0]       <= wdata_i;
    if (hi_we_i) len_q[LEN_W-1:8] <= wdata_i[HI_W-1:0];
  end

  assign len_o = len_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 14,
  localparam int LEN_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cmd_we_i,
  input  logic [1:0]       cmd_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             running_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cur_len_o,
  output logic [1:0]       mode_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic             run_q, run_d;
  logic             pend_q, pend_d;
  logic             stop_tc_q, stop_tc_d;
  logic             tc_q, tc_d;
  logic             load;
  logic [CNT_W-1:0] cnt_q, cur_len_q;
  logic [1:0]       mode_q;

  always_comb begin
    run_d     = run_q;
    pend_d    = pend_q;
    stop_tc_d = stop_tc_q;
    tc_d      = 1'b0;
    load      = 1'b0;
    if (run_q && tick_i) begin
      if (cnt_q == ONE) begin
        if (pend_q) begin
          load   = 1'b1;
          pend_d = 1'b0;
        end else if (stop_tc_q || !mode_q[0]) begin
          run_d     = 1'b0;
          stop_tc_d = 1'b0;
        end
      end else if (cnt_q == TWO) begin
        tc_d = 1'b1;
      end
    end
    if (cmd_we_i) begin
      unique case (tmr_cmd_e'(cmd_i))
        CMD_STOP: if (run_q) begin
          run_d     = 1'b0;
          pend_d    = 1'b0;
          stop_tc_d = 1'b0;
          tc_d      = 1'b0;
        end
        CMD_STOP_TC: if (run_q) begin
          stop_tc_d = 1'b1;
          pend_d    = 1'b0;
        end
        CMD_START: begin
          stop_tc_d = 1'b0;
          if (!run_q) begin
            load   = 1'b1;
            run_d  = 1'b1;
            pend_d = 1'b0;
          end else begin
            pend_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      pend_q    <= 1'b0;
      stop_tc_q <= 1'b0;
      tc_q      <= 1'b0;
    end else begin
      run_q     <= run_d;
      pend_q    <= pend_d;
      stop_tc_q <= stop_tc_d;
      tc_q      <= tc_d;
    end
  end

  // count and mode are not reset
  always_ff @(posedge clk_i) begin
    if (load) begin
      cnt_q     <= len_i[CNT_W-1:0];
      cur_len_q <= len_i[CNT_W-1:0];
      mode_q    <= len_i[LEN_W-1 -: 2];
    end else if (run_q && tick_i) begin
      cnt_q <= (cnt_q == ONE) ? cur_len_q : cnt_q - ONE;
    end
  end

  assign running_o = run_q;
  assign cnt_o     = cnt_q;
  assign cur_len_o = cur_len_q;
  assign mode_o    = mode_q;
  assign tc_o      = tc_q;
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave #(
  parameter int CNT_W = 14
) (
  input  logic             running_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cur_len_i,
  input  logic [1:0]       mode_i,
  output logic             out_o
);
  logic half_hi, pulse_hi;

  assign half_hi  = cnt_i > (cur_len_i >> 1);  // odd N: larger half high
  assign pulse_hi = cnt_i != CNT_W'(1);
  assign out_o    = !running_i || (mode_i[1] ? pulse_hi : half_hi);
endmodule

// File: rtl/prog_mode_timer.sv
module prog_mode_timer #(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W = CNT_W + 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tmr_in_i,
  input  logic       len_lo_we_i,
  input  logic       len_hi_we_i,
  input  logic [7:0] wdata_i,
  input  logic       cmd_we_i,
  input  logic [1:0] cmd_i,
  output logic       tmr_out_o,
  output logic       tc_pulse_o
);
  logic             tick_w;
  logic [LEN_W-1:0] len_w;
  logic             run_w;
  logic [CNT_W-1:0] cnt_w, cur_len_w;
  logic [1:0]       mode_w;

  tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(tmr_in_i),
    .rise_o (tick_w)
  );

  tmr_len_reg #(.CNT_W(CNT_W)) u_len (
    .clk_i  (clk_i),
    .lo_we_i(len_lo_we_i),
    .hi_we_i(len_hi_we_i),
    .wdata_i(wdata_i),
    .len_o  (len_w)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_w),
    .cmd_we_i (cmd_we_i),
    .cmd_i    (cmd_i),
    .len_i    (len_w),
    .running_o(run_w),
    .cnt_o    (cnt_w),
    .cur_len_o(cur_len_w),
    .mode_o   (mode_w),
    .tc_o     (tc_pulse_o)
  );

  tmr_wave #(.CNT_W(CNT_W)) u_wave (
    .running_i(run_w),
    .cnt_i    (cnt_w),
    .cur_len_i(cur_len_w),
    .mode_i   (mode_w),
    .out_o    (tmr_out_o)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 14,
  localparam int LEN_W = CNT_W + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_we_i,
  input logic [1:0]       cmd_i,
  input logic             tmr_out_o,
  input logic             tc_pulse_o,
  input logic             running,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [LEN_W-1:0] len
);
  p_stop_now_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i == 2'b01 |=> !running);

  p_idle_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> tmr_out_o);

  p_tc_at_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_pulse_o |-> running && cnt == CNT_W'(1));

  p_tc_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_pulse_o |=> !tc_pulse_o);

  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i == 2'b11 && !running |=>
      running && cnt == $past(len[CNT_W-1:0]));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && tick && cnt > CNT_W'(1) && !cmd_we_i |=>
      cnt == $past(cnt) - CNT_W'(1));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && !tick && !cmd_we_i |=> $stable(cnt));
endmodule

bind prog_mode_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_we_i  (cmd_we_i),
  .cmd_i     (cmd_i),
  .tmr_out_o (tmr_out_o),
  .tc_pulse_o(tc_pulse_o),
  .running   (run_w),
  .tick      (tick_w),
  .cnt       (cnt_w),
  .len       (len_w)
);

// File: tb/sim_prog_mode_timer.sv
module sim_prog_mode_timer;
  localparam int CLK_P = 10;
  localparam int NVEC  = 7;
  localparam int VEC_MODE [NVEC] = '{1, 0, 2, 3, 1, 3, 0};
  localparam int VEC_N    [NVEC] = '{9, 5, 4, 3, 2, 2, 7};
  localparam int VEC_T    [NVEC] = '{20, 8, 7, 9, 6, 5, 9};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tin = 1'b0;
  logic       lo_we = 1'b0, hi_we = 1'b0;
  logic [7:0] wdata = '0;
  logic       cmd_we = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic       tout, tc;

  int n_chk = 0, n_fail = 0, tc_seen = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  prog_mode_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tmr_in_i(tin),
    .len_lo_we_i(lo_we), .len_hi_we_i(hi_we), .wdata_i(wdata),
    .cmd_we_i(cmd_we), .cmd_i(cmd),
    .tmr_out_o(tout), .tc_pulse_o(tc)
  );

  always @(negedge clk) if (rst_n && tc) tc_seen++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_len(input int md, input int n);
    logic [15:0] w;
    w = {md[1:0], n[13:0]};
    @(negedge clk); lo_we = 1'b1; wdata = w[7:0];
    @(negedge clk); lo_we = 1'b0; hi_we = 1'b1; wdata = w[15:8];
    @(negedge clk); hi_we = 1'b0;
  endtask

  task automatic issue(input logic [1:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd = c;
    @(negedge clk); cmd_we = 1'b0; cmd = 2'b00;
  endtask

  task automatic tick();
    @(negedge clk); tin = 1'b1;
    @(negedge clk);
    @(negedge clk); tin = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_out(int md, int n, int c, bit run);
    if (!run) return 1;
    if (md < 2) return (c > n / 2) ? 1 : 0;
    return (c != 1) ? 1 : 0;
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R12 reset output high", tout, 1);
    chk("R11 reset no tc", tc, 0);
    rst_n = 1'b1;
    // ticks before any START: nothing counts
    for (int i = 0; i < 3; i++) tick();
    chk("R12 no count before START out", tout, 1);
    chk("R11 no tc while idle", tc_seen, 0);

    // vector table: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      int md, n, tmax, tc_exp;
      md = VEC_MODE[v]; n = VEC_N[v]; tmax = VEC_T[v];
      issue(2'b01);
      write_len(md, n);
      base = tc_seen;
      issue(2'b11);
      tc_exp = 0;
      for (int k = 0; k <= tmax; k++) begin
        bit run;
        if (k > 0) tick();
        run = (md % 2 == 1) || (k < n);
        if (k > 0 && k % n == n - 1 && ((md % 2 == 1) || k == n - 1)) tc_exp++;
        chk($sformatf("R3/R4/R5 vec%0d tick%0d out", v, k), tout,
            exp_out(md, n, n - (k % n), run));
      end
      chk($sformatf("R1/R2/R6 vec%0d tc count", v), tc_seen - base, tc_exp);
    end

    // R7: NOP during run
    issue(2'b01);
    write_len(1, 4);
    issue(2'b11);
    tick();                          // c=3
    issue(2'b00);
    tick(); chk("R7 nop c=2", tout, 0);
    tick(); chk("R7 nop c=1", tout, 0);
    tick(); chk("R7 nop reload c=4", tout, 1);

    // R8: immediate stop
    issue(2'b01);
    write_len(3, 5);
    issue(2'b11);
    tick(); tick();
    base = tc_seen;
    issue(2'b01);
    chk("R8 stop out high", tout, 1);
    for (int i = 0; i < 6; i++) tick();
    chk("R8 stop no tc", tc_seen - base, 0);
    chk("R8 stop out stays high", tout, 1);

    // R9: stop after terminal count
    write_len(1, 4);
    issue(2'b11);
    base = tc_seen;
    tick();                          // c=3
    issue(2'b10);
    tick(); chk("R9 c=2 low", tout, 0);
    tick(); chk("R9 c=1 low", tout, 0);
    chk("R9 tc of last period", tc_seen - base, 1);
    tick(); chk("R9 stopped high", tout, 1);
    for (int i = 0; i < 4; i++) tick();
    chk("R9 no tc after stop", tc_seen - base, 1);
    chk("R9 still high", tout, 1);

    // R9: stop-after-tc while idle is ignored
    issue(2'b10);
    write_len(3, 3);
    issue(2'b11);
    base = tc_seen;
    for (int i = 0; i < 7; i++) tick();
    chk("R9 idle cmd ignored tc", tc_seen - base, 2);
    chk("R9 idle cmd ignored out", tout, 1);

    // R10: START while running is deferred to the wrap
    issue(2'b01);
    write_len(1, 6);
    issue(2'b11);
    base = tc_seen;
    tick(); tick();                  // c=4
    write_len(3, 3);
    issue(2'b11);
    chk("R10 old mode c=4", tout, 1);
    tick(); chk("R10 old mode c=3 low", tout, 0);
    tick(); chk("R10 old mode c=2 low", tout, 0);
    tick(); chk("R10 old mode c=1 low", tout, 0);
    tick(); chk("R10 new c=3 high", tout, 1);
    tick(); chk("R10 new c=2 high", tout, 1);
    tick(); chk("R10 new c=1 low", tout, 0);
    tick(); chk("R10 new reload c=3", tout, 1);
    chk("R10 tc count", tc_seen - base, 2);

    // R12: reset mid-run, length word kept
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset mid-run out", tout, 1);
    rst_n = 1'b1;
    base = tc_seen;
    for (int i = 0; i < 4; i++) tick();
    chk("R12 halted no tc", tc_seen - base, 0);
    chk("R12 halted out", tout, 1);
    issue(2'b11);
    tick(); tick();
    chk("R12 kept length c=1 low", tout, 0);
    chk("R12 kept length tc", tc_seen - base, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule